// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block manages the power states of a DSP core from a single input clock. A power-down request, coming either from an active-low request pin or from a software force strobe, first becomes a nonmaskable interrupt pulse. The handler may run as long as it needs and then commits with a separate strobe. Once committed, the sequencer stops the core and derived clocks and raises an acknowledge. If the design runs from a crystal and the oscillator-disable option was chosen, it also switches the oscillator off. A rising edge on the request pin starts the restart count: 100 input cycles in the fast case, 4096 when the oscillator was stopped. After that count the clocks are released, and a context-clear pulse is optionally raised. Reset ends power-down at once.

The sequencer also runs the two idle modes. Standard idle keeps every clock running at full rate while the core waits for an interrupt. Slow idle divides the core clock and all derived clocks (serial, timer, clock-out) by one shared ratio of 16, 32, 64 or 128, given as a 2-bit code. Both idle modes end when an interrupt is pending.

Top module: `lpm_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, the block is in the running state: core_clk_en=1, per_clk_en=1, pd_ack=0, osc_en=1, ctx_clear=0, pd_irq=0.
- R2: In the running or idle state, a high-to-low change on pwrdn_n, or sw_force=1, gives pd_irq=1 for the cycle after the clock edge that samples it. The clocks keep running.
- R3: pd_commit=1 in the running state stops the clocks from the next cycle on: core_clk_en=0, per_clk_en=0, clkout_en=0, pd_ack=1.
- R4: During power-down, osc_en is 0 only when xtal_mode=1 and osc_off=1 were sampled with the commit. In every other state osc_en is 1.
- R5: When the oscillator was kept running, core_clk_en returns to 1 exactly 100 cycles after the clock edge that samples the low-to-high change of pwrdn_n.
- R6: When the oscillator was stopped, that delay is 4096 cycles.
- R7: If pwrdn_n falls again during the restart count, the block returns to power-down. pd_ack stays 1 and the clocks stay off. The next rise restarts the full delay.
- R8: Asserting rst_n=0 during power-down returns the block to the running state at once.
- R9: ctx_clear is a one-cycle pulse in the first running cycle after a wake-up, and only when ctx_sel=1 was sampled with the commit. Otherwise it stays 0.
- R10: idle_cmd with idle_div_en=0 enters standard idle, in which core_clk_en and per_clk_en stay 1 every cycle.
- R11: idle_cmd with idle_div_en=1 enters slow idle with ratio N = 16 << idle_div (00=16, 01=32, 10=64, 11=128). core_clk_en and per_clk_en are then high together for one cycle in every N, first N-1 cycles after the entering edge.
- R12: irq_pending=1 in either idle state returns the block to full-rate running from the next cycle.
- R13: clkout_en equals per_clk_en while clkout_dis=0 and is 0 while clkout_dis=1.
- R14: pd_commit outside the running state and idle_cmd outside the running state are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset; also ends power-down |
| pwrdn_n | input | 1 | Active-low power-down request pin, synchronous to clk |
| sw_force | input | 1 | Software power-down force strobe |
| pd_commit | input | 1 | Handler commits to power-down |
| xtal_mode | input | 1 | 1 = crystal clock source, 0 = external clock |
| osc_off | input | 1 | Stop the oscillator during power-down (crystal only) |
| ctx_sel | input | 1 | 1 = start from a cleared context on wake-up |
| idle_cmd | input | 1 | Idle command strobe |
| idle_div_en | input | 1 | Idle command carries a divisor (slow idle) |
| idle_div | input | 2 | Divisor code: 00=16, 01=32, 10=64, 11=128 |
| irq_pending | input | 1 | An unmasked interrupt is pending |
| clkout_dis | input | 1 | Disable the clock-out pin |
| core_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Derived-clock enable strobe (serial, timer) |
| clkout_en | output | 1 | Clock-out enable |
| pd_ack | output | 1 | Power-down acknowledge |
| osc_en | output | 1 | Oscillator enable |
| ctx_clear | output | 1 | Context-clear pulse at resume |
| pd_irq | output | 1 | Nonmaskable power-down interrupt pulse |

## Verification
If the state register holds the wrong value, the next sampled cycle shows it: pd_ack and the clock enables disagree with the last commit or wake event. A wake counter that is off by any amount moves the rise of core_clk_en away from cycle 100 or 4096, and the bench measures that rise exactly. A wrong divider limit or ratio code shifts the first slow-idle strobe off cycle N-1 or changes the pulse count within 3N cycles. A wrong latch of the oscillator or context choice shows up as osc_en or ctx_clear in the wrong cycle during the same power-down episode.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int DIV_SEL_W = 2;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_IDLE = 2'd1,
        ST_PD   = 2'd2,
        ST_WAKE = 2'd3
    } lpm_state_e;

    typedef struct packed {
        lpm_state_e           state;
        logic                 pin;
        logic                 slow_wake;
        logic                 ctx_sel;
        logic [DIV_SEL_W-1:0] div_sel;
        logic                 div_on;
        logic                 pd_irq;
        logic                 ctx_clear;
    } lpm_regs_t;

endpackage

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
    parameter int FAST_CYC = 100,
    parameter int SLOW_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic done
);
    localparam int MAXC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit = slow ? CW'(SLOW_CYC - 1) : CW'(FAST_CYC - 1);
        done  = run && (cnt_q == limit);
        if (!run)      cnt_d = '0;
        else if (done) cnt_d = '0;
        else           cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // The count never passes its limit while the restart is in progress.
    AST_WAKE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q <= limit); // R6

endmodule

// File: rtl/lpm_clk_div.sv
module lpm_clk_div #(
    parameter int BASE_DIV = 16,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             stb
);
    localparam int MAXDIV = BASE_DIV << ((1 << SEL_W) - 1);
    localparam int CW     = $clog2(MAXDIV);
    localparam int RW     = CW + 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [RW-1:0] ratio;
    logic [CW-1:0] limit;

    always_comb begin
        ratio = RW'(BASE_DIV) << sel;
        limit = CW'(ratio - RW'(1));
        stb   = en && (cnt_q == limit);
        if (!en)      cnt_d = '0;
        else if (stb) cnt_d = '0;
        else          cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> cnt_q <= limit); // R11

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int FAST_WAKE = 100,
    parameter int SLOW_WAKE = 4096,
    parameter int BASE_DIV  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwrdn_n,
    input  logic                 sw_force,
    input  logic                 pd_commit,
    input  logic                 xtal_mode,
    input  logic                 osc_off,
    input  logic                 ctx_sel,
    input  logic                 idle_cmd,
    input  logic                 idle_div_en,
    input  logic [DIV_SEL_W-1:0] idle_div,
    input  logic                 irq_pending,
    input  logic                 clkout_dis,
    output logic                 core_clk_en,
    output logic                 per_clk_en,
    output logic                 clkout_en,
    output logic                 pd_ack,
    output logic                 osc_en,
    output logic                 ctx_clear,
    output logic                 pd_irq
);
    lpm_regs_t r_d, r_q;
    logic      wake_done;
    logic      div_stb;
    logic      pin_fall, pin_rise;
    logic      awake;

    lpm_wake_timer #(
        .FAST_CYC (FAST_WAKE),
        .SLOW_CYC (SLOW_WAKE)
    ) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.state == ST_WAKE),
        .slow  (r_q.slow_wake),
        .done  (wake_done)
    );

    lpm_clk_div #(
        .BASE_DIV (BASE_DIV),
        .SEL_W    (DIV_SEL_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    ((r_q.state == ST_IDLE) && r_q.div_on),
        .sel   (r_q.div_sel),
        .stb   (div_stb)
    );

    always_comb begin
        r_d       = r_q;
        pin_fall  = r_q.pin && !pwrdn_n;
        pin_rise  = !r_q.pin && pwrdn_n;
        awake     = (r_q.state == ST_RUN) || (r_q.state == ST_IDLE);
        r_d.pin   = pwrdn_n;
        r_d.pd_irq    = awake && (sw_force || pin_fall);
        r_d.ctx_clear = 1'b0;

        unique case (r_q.state)
            ST_RUN: begin
                if (pd_commit) begin
                    r_d.state     = ST_PD;
                    r_d.slow_wake = xtal_mode && osc_off;
                    r_d.ctx_sel   = ctx_sel;
                end else if (idle_cmd) begin
                    r_d.state   = ST_IDLE;
                    r_d.div_on  = idle_div_en;
                    r_d.div_sel = idle_div;
                end
            end
            ST_IDLE: begin
                if (irq_pending) begin
                    r_d.state  = ST_RUN;
                    r_d.div_on = 1'b0;
                end
            end
            ST_PD: begin
                if (pin_rise) r_d.state = ST_WAKE;
            end
            ST_WAKE: begin
                if (!pwrdn_n) begin
                    r_d.state = ST_PD;
                end else if (wake_done) begin
                    r_d.state     = ST_RUN;
                    r_d.ctx_clear = r_q.ctx_sel;
                end
            end
            default: r_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.state     <= ST_RUN;
            r_q.pin       <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.state)
            ST_RUN:  core_clk_en = 1'b1;
            ST_IDLE: core_clk_en = !r_q.div_on || div_stb;
            default: core_clk_en = 1'b0;
        endcase
        per_clk_en = core_clk_en;
        clkout_en  = per_clk_en && !clkout_dis;
        pd_ack     = (r_q.state == ST_PD) || (r_q.state == ST_WAKE);
        osc_en     = !((r_q.state == ST_PD) && r_q.slow_wake);
        ctx_clear  = r_q.ctx_clear;
        pd_irq     = r_q.pd_irq;
    end

    AST_ACK_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        pd_ack |-> !core_clk_en && !per_clk_en); // R3

    AST_OSC_IN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAKE) |-> osc_en); // R4

    AST_CTX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_clear |=> !ctx_clear); // R9

    AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == ST_IDLE) && irq_pending) |=> core_clk_en); // R12

    AST_CLKOUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        clkout_dis |-> !clkout_en); // R13

endmodule

// File: tb/tb_lpm_sequencer.sv
module tb_lpm_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwrdn_n = 1'b1, sw_force = 1'b0, pd_commit = 1'b0;
    logic       xtal_mode = 1'b0, osc_off = 1'b0, ctx_sel = 1'b0;
    logic       idle_cmd = 1'b0, idle_div_en = 1'b0, irq_pending = 1'b0;
    logic [1:0] idle_div = 2'd0;
    logic       clkout_dis = 1'b0;
    logic       core_clk_en, per_clk_en, clkout_en, pd_ack, osc_en, ctx_clear, pd_irq;

    int n_chk = 0;
    int n_fail = 0;

    // {divisor code, clock-out disable, expected ratio}
    localparam logic [10:0] VEC [4] = '{
        {2'd0, 1'b0, 8'd16},
        {2'd1, 1'b1, 8'd32},
        {2'd2, 1'b0, 8'd64},
        {2'd3, 1'b1, 8'd128}
    };

    always #4 clk = ~clk;

    lpm_sequencer dut (
        .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .sw_force(sw_force),
        .pd_commit(pd_commit), .xtal_mode(xtal_mode), .osc_off(osc_off),
        .ctx_sel(ctx_sel), .idle_cmd(idle_cmd), .idle_div_en(idle_div_en),
        .idle_div(idle_div), .irq_pending(irq_pending), .clkout_dis(clkout_dis),
        .core_clk_en(core_clk_en), .per_clk_en(per_clk_en), .clkout_en(clkout_en),
        .pd_ack(pd_ack), .osc_en(osc_en), .ctx_clear(ctx_clear), .pd_irq(pd_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Counts sampled cycles until the core clock returns; also counts ctx pulses
    // and oscillator-off samples seen on the way.
    task automatic wait_core(output int n, output int osc_low, output int ctx_hi);
        n = 0; osc_low = 0; ctx_hi = 0;
        for (int g = 0; g < 10000; g++) begin
            tick();
            if (ctx_clear) ctx_hi++;
            if (core_clk_en) break;
            if (!osc_en) osc_low++;
            n++;
        end
    endtask

    task automatic commit_pd();
        pwrdn_n = 1'b0;
        pd_commit = 1'b1;
        tick();
        pd_commit = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n, ol, ch, first, cnt, ck, mism;
        @(negedge clk);
        chk("R1 core in reset", int'(core_clk_en), 1);
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R1 core", int'(core_clk_en), 1);
        chk("R1 per", int'(per_clk_en), 1);
        chk("R1 ack", int'(pd_ack), 0);
        chk("R1 osc", int'(osc_en), 1);
        chk("R1 ctx", int'(ctx_clear), 0);
        chk("R1 irq", int'(pd_irq), 0);

        // R2 pin edge
        pwrdn_n = 1'b0; tick();
        chk("R2 pin irq", int'(pd_irq), 1);
        chk("R2 clocks run", int'(core_clk_en), 1);
        tick();
        chk("R2 pin irq pulse", int'(pd_irq), 0);
        pwrdn_n = 1'b1; tick();
        // R2 software force
        sw_force = 1'b1; tick(); sw_force = 1'b0;
        chk("R2 force irq", int'(pd_irq), 1);
        tick();
        chk("R2 force irq pulse", int'(pd_irq), 0);

        // R3/R4/R5/R9 fast wake with context clear
        ctx_sel = 1'b1; xtal_mode = 1'b0; osc_off = 1'b1;
        commit_pd();
        chk("R3 ack", int'(pd_ack), 1);
        chk("R3 core", int'(core_clk_en), 0);
        chk("R3 per", int'(per_clk_en), 0);
        chk("R3 clkout", int'(clkout_en), 0);
        chk("R4 osc ext clock", int'(osc_en), 1);
        idle_cmd = 1'b1; idle_div_en = 1'b1; tick(); idle_cmd = 1'b0;  // R14
        chk("R14 idle in pd ignored", int'(pd_ack), 1);
        tick(); tick();
        pwrdn_n = 1'b1;
        wait_core(n, ol, ch);
        chk("R5 fast delay", n, 100);
        chk("R9 ctx pulse", int'(ctx_clear), 1);
        tick();
        chk("R9 ctx one cycle", int'(ctx_clear), 0);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin tick(); cnt += int'(core_clk_en); end
        chk("R14 full rate after wake", cnt, 40);

        // R7 restart
        commit_pd();
        pwrdn_n = 1'b1;
        repeat (50) tick();
        pwrdn_n = 1'b0; tick(); tick();
        chk("R7 ack", int'(pd_ack), 1);
        chk("R7 core", int'(core_clk_en), 0);
        pwrdn_n = 1'b1;
        wait_core(n, ol, ch);
        chk("R7 restart delay", n, 100);

        // R4/R6/R9 slow wake, no context clear
        xtal_mode = 1'b1; osc_off = 1'b1; ctx_sel = 1'b0;
        commit_pd();
        chk("R4 osc stopped", int'(osc_en), 0);
        pwrdn_n = 1'b1;
        wait_core(n, ol, ch);
        chk("R6 slow delay", n, 4096);
        chk("R4 osc on during wake", ol, 0);
        chk("R9 no ctx pulse", ch, 0);
        chk("R4 osc after wake", int'(osc_en), 1);

        // R8 reset ends power-down
        xtal_mode = 1'b0;
        commit_pd();
        chk("R8 in pd", int'(pd_ack), 1);
        rst_n = 1'b0; tick();
        chk("R8 ack", int'(pd_ack), 0);
        chk("R8 core", int'(core_clk_en), 1);
        rst_n = 1'b1; pwrdn_n = 1'b1; tick();

        // R10 standard idle, R14 commit in idle
        idle_cmd = 1'b1; idle_div_en = 1'b0; tick(); idle_cmd = 1'b0;
        cnt = 0;
        for (int i = 0; i < 30; i++) begin tick(); cnt += int'(core_clk_en & per_clk_en); end
        chk("R10 standard idle full rate", cnt, 30);
        pd_commit = 1'b1; tick(); pd_commit = 1'b0;
        chk("R14 commit in idle ignored", int'(pd_ack), 0);
        irq_pending = 1'b1; tick(); irq_pending = 1'b0;

        // R11/R12/R13 table of slow-idle ratios
        for (int v = 0; v < 4; v++) begin
            int nr;
            nr = int'(VEC[v][7:0]);
            idle_div = VEC[v][10:9];
            clkout_dis = VEC[v][8];
            idle_div_en = 1'b1; idle_cmd = 1'b1;
            tick();
            idle_cmd = 1'b0;
            first = -1; cnt = 0; ck = 0; mism = 0;
            for (int j = 0; j < 3 * nr; j++) begin
                if (j > 0) tick();
                if (core_clk_en) begin cnt++; if (first < 0) first = j; end
                if (core_clk_en != per_clk_en) mism++;
                ck += int'(clkout_en);
            end
            chk("R11 first strobe", first, nr - 1);
            chk("R11 strobe count", cnt, 3);
            chk("R11 shared ratio", mism, 0);
            chk("R13 clkout", ck, VEC[v][8] ? 0 : 3);
            irq_pending = 1'b1; tick(); irq_pending = 1'b0;
            chk("R12 exit idle", int'(core_clk_en), 1);
            tick();
            chk("R12 full rate", int'(core_clk_en), 1);
        end
        clkout_dis = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule